// File: doc/BRIEF.md
# Dual-Channel Field Change Detector

This block watches sample streams from two 10-bit converters, one on a low-frequency antenna and one on a high-frequency antenna, and tells whether an outside reader is energising either antenna. Samples arrive one at a time on a single valid-qualified input tagged with a channel id (0 = low frequency, 1 = high frequency). An external sequencer alternates between the channels. The first accepted sample of a channel becomes that channel's frozen baseline and also its first reference value. The block reports this baseline once.

After that, each new sample of a channel is compared with that channel's tracked reference. A move larger than the margin produces a change event. The event carries the previous reference, the new sample and the number of samples taken since the reference was last updated. The new sample then becomes the reference. A per-channel presence flag shows whether the current reference has drifted from the baseline by more than the margin.

A two-bit mode input enables one channel or both. A stop input ends monitoring until the next reset.

Top module: `field_watch`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0: both presence flags, the baseline report and the change event.
- R2: Mode value 1 enables only channel 0 and mode value 2 enables only channel 1. Values 0 and 3 enable both. A sample tagged with a disabled channel produces no report and leaves that channel's presence flag at 0.
- R3: The first accepted sample of a channel is latched as its baseline and its reference. One cycle later `base_valid` pulses for one cycle with the channel id and the value. This happens only once per channel until reset, and no change event of a channel comes before its baseline report.
- R4: Each later accepted sample adds one to that channel's counter. When |sample − reference| > 10, `evt_valid` pulses one cycle later for one cycle with the channel id, the old reference, the new sample and the incremented count. The reference then takes the sample and the counter returns to 0.
- R5: A difference of exactly 10 does not produce an event. The reference is kept and the counter continues to count.
- R6: A channel's presence flag is 1 while |reference − baseline| > 10. It changes in the same cycle that the change event of the reference update appears.
- R7: A sample or an event on one channel leaves the other channel's reference, counter and presence flag unchanged.
- R8: On the cycle after `stop` is high, both presence flags are 0. From then until reset, no baseline report and no change event appears. A sample offered in the same cycle as `stop` is ignored.
- R9: The sample counter saturates at 2^CNT_W − 1. It does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Channel enable: 1 = channel 0 only, 2 = channel 1 only, else both |
| stop | input | 1 | Ends monitoring until reset |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_chan | input | 1 | Channel of the offered sample (0 low, 1 high frequency) |
| smp_data | input | DW | Converter reading |
| lf_present | output | 1 | Channel 0 field presence |
| hf_present | output | 1 | Channel 1 field presence |
| base_valid | output | 1 | One-cycle baseline report |
| base_chan | output | 1 | Channel of the baseline report |
| base_value | output | DW | Baseline value |
| evt_valid | output | 1 | One-cycle change event |
| evt_chan | output | 1 | Channel of the change event |
| evt_old | output | DW | Reference before the change |
| evt_new | output | DW | Sample that caused the change |
| evt_count | output | CNT_W | Samples since the previous reference update |

## Verification
A stop request can coincide with a sample that would otherwise raise a change event and set a presence flag. The bench provokes this by raising `stop` in the same cycle as a low-frequency sample 500 counts away from the reference, while that channel's flag is already on. It then expects no event and both flags low on the next cycle. A change event and a presence update come from the same sample and fall in one cycle. The bench checks both in that cycle against a behavioural model that it compares on every clock, across directed steps, the exact-margin boundary and a randomised walk on both channels.

// File: rtl/fw_pkg.sv
package fw_pkg;

  localparam logic CH_LF = 1'b0;
  localparam logic CH_HF = 1'b1;

  typedef enum logic [1:0] {
    WATCH_BOTH  = 2'd0,
    WATCH_LF    = 2'd1,
    WATCH_HF    = 2'd2,
    WATCH_BOTH2 = 2'd3
  } watch_mode_e;

  // bit 0: low-frequency channel enabled, bit 1: high-frequency channel enabled
  function automatic logic [1:0] chan_enables(input logic [1:0] m);
    case (watch_mode_e'(m))
      WATCH_LF: chan_enables = 2'b01;
      WATCH_HF: chan_enables = 2'b10;
      default:  chan_enables = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/fw_chan.sv
module fw_chan #(
  parameter int DW     = 10,
  parameter int CW     = 16,
  parameter int MARGIN = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          clr,
  input  logic [DW-1:0] data,
  output logic          base_fire,
  output logic          chg_fire,
  output logic          present,
  output logic [DW-1:0] ref_val,
  output logic [CW-1:0] cnt_next
);

  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [DW-1:0] MARGIN_V = DW'(MARGIN);

  logic          have_base;
  logic [DW-1:0] base_q;
  logic [DW-1:0] ref_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] diff_ref;
  logic [DW-1:0] diff_base;
  logic          moved;

  always_comb begin
    diff_ref  = (data >= ref_q)  ? (data - ref_q)  : (ref_q - data);
    diff_base = (data >= base_q) ? (data - base_q) : (base_q - data);
    moved     = diff_ref > MARGIN_V;
    base_fire = take && !have_base;
    chg_fire  = take && have_base && moved;
    cnt_next  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
    ref_val   = ref_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_base <= 1'b0;
      base_q    <= '0;
      ref_q     <= '0;
      cnt_q     <= '0;
      present   <= 1'b0;
    end else begin
      if (base_fire) begin
        have_base <= 1'b1;
        base_q    <= data;
        ref_q     <= data;
        cnt_q     <= '0;
      end else if (take) begin
        if (moved) begin
          ref_q   <= data;
          cnt_q   <= '0;
          present <= diff_base > MARGIN_V;
        end else begin
          cnt_q   <= cnt_next;
        end
      end
      if (clr) present <= 1'b0;
    end
  end

endmodule

// File: rtl/fw_report.sv
module fw_report #(
  parameter int DW = 10,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                chan,
  input  logic [DW-1:0]       data,
  input  logic [1:0]          base_fire,
  input  logic [1:0]          chg_fire,
  input  logic [1:0][DW-1:0]  ref_val,
  input  logic [1:0][CW-1:0]  cnt_next,
  output logic                base_valid,
  output logic                base_chan,
  output logic [DW-1:0]       base_value,
  output logic                evt_valid,
  output logic                evt_chan,
  output logic [DW-1:0]       evt_old,
  output logic [DW-1:0]       evt_new,
  output logic [CW-1:0]       evt_count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_valid <= 1'b0;
      base_chan  <= 1'b0;
      base_value <= '0;
      evt_valid  <= 1'b0;
      evt_chan   <= 1'b0;
      evt_old    <= '0;
      evt_new    <= '0;
      evt_count  <= '0;
    end else begin
      base_valid <= |base_fire;
      evt_valid  <= |chg_fire;
      if (|base_fire) begin
        base_chan  <= chan;
        base_value <= data;
      end
      if (|chg_fire) begin
        evt_chan  <= chan;
        evt_old   <= ref_val[chan];
        evt_new   <= data;
        evt_count <= cnt_next[chan];
      end
    end
  end

endmodule

// File: rtl/field_watch.sv
module field_watch #(
  parameter int DW     = 10,
  parameter int CNT_W  = 16,
  parameter int MARGIN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             stop,
  input  logic             smp_valid,
  input  logic             smp_chan,
  input  logic [DW-1:0]    smp_data,
  output logic             lf_present,
  output logic             hf_present,
  output logic             base_valid,
  output logic             base_chan,
  output logic [DW-1:0]    base_value,
  output logic             evt_valid,
  output logic             evt_chan,
  output logic [DW-1:0]    evt_old,
  output logic [DW-1:0]    evt_new,
  output logic [CNT_W-1:0] evt_count
);

  localparam int NCH = 2;

  logic                       stopped;
  logic [NCH-1:0]             chan_en;
  logic                       halt;
  logic [NCH-1:0]             base_fire;
  logic [NCH-1:0]             chg_fire;
  logic [NCH-1:0]             pres;
  logic [NCH-1:0][DW-1:0]     ref_val;
  logic [NCH-1:0][CNT_W-1:0]  cnt_next;

  assign chan_en = fw_pkg::chan_enables(mode);
  assign halt    = stop || stopped;

  always_ff @(posedge clk) begin
    if (rst)       stopped <= 1'b0;
    else if (stop) stopped <= 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fw_chan #(.DW(DW), .CW(CNT_W), .MARGIN(MARGIN)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .take      (smp_valid && (smp_chan == 1'(g)) && chan_en[g] && !halt),
      .clr       (halt),
      .data      (smp_data),
      .base_fire (base_fire[g]),
      .chg_fire  (chg_fire[g]),
      .present   (pres[g]),
      .ref_val   (ref_val[g]),
      .cnt_next  (cnt_next[g])
    );
  end

  fw_report #(.DW(DW), .CW(CNT_W)) u_report (
    .clk        (clk),
    .rst        (rst),
    .chan       (smp_chan),
    .data       (smp_data),
    .base_fire  (base_fire),
    .chg_fire   (chg_fire),
    .ref_val    (ref_val),
    .cnt_next   (cnt_next),
    .base_valid (base_valid),
    .base_chan  (base_chan),
    .base_value (base_value),
    .evt_valid  (evt_valid),
    .evt_chan   (evt_chan),
    .evt_old    (evt_old),
    .evt_new    (evt_new),
    .evt_count  (evt_count)
  );

  assign lf_present = pres[fw_pkg::CH_LF];
  assign hf_present = pres[fw_pkg::CH_HF];

endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int DW     = 10,
  parameter int MARGIN = 10
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic          stop,
  input logic          stopped,
  input logic          lf_present,
  input logic          hf_present,
  input logic          base_valid,
  input logic          base_chan,
  input logic          evt_valid,
  input logic          evt_chan,
  input logic [DW-1:0] evt_old,
  input logic [DW-1:0] evt_new
);

  logic          seen_lf;
  logic          seen_hf;
  logic [DW-1:0] evt_gap;

  assign evt_gap = (evt_new >= evt_old) ? (evt_new - evt_old) : (evt_old - evt_new);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_lf <= 1'b0;
      seen_hf <= 1'b0;
    end else if (base_valid) begin
      if (base_chan) seen_hf <= 1'b1;
      else           seen_lf <= 1'b1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !base_valid && !evt_valid && !lf_present && !hf_present);

  p_lf_only_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'd1) |-> !(evt_valid && evt_chan) && !(base_valid && base_chan));

  p_hf_only_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == 2'd2) |-> !(evt_valid && !evt_chan) && !(base_valid && !base_chan));

  p_base_once_r3: assert property (@(posedge clk) disable iff (rst)
    base_valid |-> !(base_chan ? seen_hf : seen_lf));

  p_evt_after_base_r3: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (evt_chan ? seen_hf : seen_lf));

  p_evt_margin_r4: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> evt_gap > DW'(MARGIN));

  p_stop_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(stop && !rst) |-> stopped);

  p_stopped_silent_r8: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !base_valid && !evt_valid && !lf_present && !hf_present);

endmodule

bind field_watch fw_checker #(.DW(DW), .MARGIN(MARGIN)) u_fw_checker (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .stop       (stop),
  .stopped    (stopped),
  .lf_present (lf_present),
  .hf_present (hf_present),
  .base_valid (base_valid),
  .base_chan  (base_chan),
  .evt_valid  (evt_valid),
  .evt_chan   (evt_chan),
  .evt_old    (evt_old),
  .evt_new    (evt_new)
);

// File: tb/tb_field_watch.sv
module tb_field_watch;
  localparam int DW     = 10;
  localparam int CW     = 16;
  localparam int MARGIN = 10;
  localparam int MAXC   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic          stop = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_chan = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          lf_present, hf_present, base_valid, base_chan, evt_valid, evt_chan;
  logic [DW-1:0] base_value, evt_old, evt_new;
  logic [CW-1:0] evt_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  field_watch #(.DW(DW), .CNT_W(CW), .MARGIN(MARGIN)) dut (
    .clk(clk), .rst(rst), .mode(mode), .stop(stop), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .lf_present(lf_present),
    .hf_present(hf_present), .base_valid(base_valid), .base_chan(base_chan),
    .base_value(base_value), .evt_valid(evt_valid), .evt_chan(evt_chan),
    .evt_old(evt_old), .evt_new(evt_new), .evt_count(evt_count)
  );

  // behavioural reference model
  int m_have[2], m_base[2], m_ref[2], m_cnt[2], m_pres[2];
  int m_stopped;
  int e_bv, e_bc, e_bval, e_ev, e_ec, e_eo, e_en, e_ecnt;

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int en_of(input int md, input int ch);
    if (md == 1) return (ch == 0) ? 1 : 0;
    if (md == 2) return (ch == 1) ? 1 : 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_have[c] = 0; m_base[c] = 0; m_ref[c] = 0; m_cnt[c] = 0; m_pres[c] = 0;
      end
      m_stopped = 0;
      e_bv = 0; e_ev = 0;
    end else begin
      e_bv = 0; e_ev = 0;
      if (stop || m_stopped != 0) begin
        m_stopped = 1;
        m_pres[0] = 0; m_pres[1] = 0;
      end else if (smp_valid && en_of(int'(mode), int'(smp_chan)) != 0) begin
        int c, d, inc;
        c = int'(smp_chan);
        d = int'(smp_data);
        if (m_have[c] == 0) begin
          m_have[c] = 1; m_base[c] = d; m_ref[c] = d; m_cnt[c] = 0;
          e_bv = 1; e_bc = c; e_bval = d;
        end else begin
          inc = (m_cnt[c] == MAXC) ? MAXC : m_cnt[c] + 1;
          if (absd(d, m_ref[c]) > MARGIN) begin
            e_ev = 1; e_ec = c; e_eo = m_ref[c]; e_en = d; e_ecnt = inc;
            m_ref[c] = d; m_cnt[c] = 0;
            m_pres[c] = (absd(d, m_base[c]) > MARGIN) ? 1 : 0;
          end else begin
            m_cnt[c] = inc;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6", "lf_present", int'(lf_present), m_pres[0]);
      chk("R6", "hf_present", int'(hf_present), m_pres[1]);
      chk("R3", "base_valid", int'(base_valid), e_bv);
      if (e_bv != 0) begin
        chk("R3", "base_chan", int'(base_chan), e_bc);
        chk("R3", "base_value", int'(base_value), e_bval);
      end
      chk("R4", "evt_valid", int'(evt_valid), e_ev);
      if (e_ev != 0) begin
        chk("R4", "evt_chan", int'(evt_chan), e_ec);
        chk("R4", "evt_old", int'(evt_old), e_eo);
        chk("R4", "evt_new", int'(evt_new), e_en);
        chk("R4", "evt_count", int'(evt_count), e_ecnt);
      end
    end
  end

  task automatic do_reset(input logic [1:0] md);
    rst = 1'b1; mode = md; stop = 1'b0; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset",
        int'({lf_present, hf_present, base_valid, evt_valid}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset",
        int'({lf_present, hf_present, base_valid, evt_valid}), 0);
  endtask

  // offered at a falling edge; returns at the next falling edge, outputs visible
  task automatic send(input int ch, input int d);
    smp_valid = 1'b1; smp_chan = ch[0]; smp_data = d[DW-1:0];
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // both channels enabled
    do_reset(2'd0);
    send(0, 500);
    chk("R3", "lf baseline report", int'({base_valid, base_chan}), 2);
    chk("R3", "lf baseline value", int'(base_value), 500);
    send(1, 200);
    chk("R3", "hf baseline report", int'({base_valid, base_chan}), 3);
    send(0, 505);
    chk("R4", "small move no event", int'(evt_valid), 0);
    send(0, 490);
    chk("R5", "diff exactly 10 no event", int'(evt_valid), 0);
    send(0, 511);
    chk("R4", "event fires", int'({evt_valid, evt_chan}), 2);
    chk("R4", "event old/new", int'(evt_old) * 1024 + int'(evt_new), 500 * 1024 + 511);
    chk("R5", "count kept through margin sample", int'(evt_count), 3);
    chk("R6", "lf presence on", int'(lf_present), 1);
    chk("R7", "hf presence untouched", int'(hf_present), 0);
    send(1, 200);
    chk("R7", "hf sample keeps lf presence", int'({lf_present, evt_valid}), 2);
    send(0, 500);
    chk("R4", "count reset after event", int'(evt_count), 1);
    chk("R6", "lf presence off", int'(lf_present), 0);
    send(0, 500);
    chk("R3", "no second baseline", int'(base_valid), 0);
    for (int i = 0; i < 300; i++) begin
      if (i % 2 == 0) send(0, 480 + $urandom_range(0, 40));
      else            send(1, 180 + $urandom_range(0, 40));
    end
    send(0, 700);
    chk("R6", "lf presence before stop", int'(lf_present), 1);
    stop = 1'b1; smp_valid = 1'b1; smp_chan = 1'b0; smp_data = 10'd200;
    @(negedge clk);
    stop = 1'b0; smp_valid = 1'b0;
    chk("R8", "sample with stop ignored", int'(evt_valid), 0);
    chk("R8", "presence cleared", int'({lf_present, hf_present}), 0);
    send(1, 900);
    chk("R8", "silent after stop", int'({base_valid, evt_valid, hf_present}), 0);

    // low-frequency only
    do_reset(2'd1);
    send(1, 300);
    chk("R2", "hf sample ignored in mode 1", int'(base_valid), 0);
    send(0, 100);
    chk("R2", "lf baseline in mode 1", int'({base_valid, base_chan}), 2);
    send(1, 800);
    chk("R2", "hf stays dark in mode 1", int'({evt_valid, hf_present}), 0);
    smp_valid = 1'b1; smp_chan = 1'b0; smp_data = 10'd100;
    repeat (MAXC + 5) @(negedge clk);
    smp_valid = 1'b0;
    send(0, 300);
    chk("R9", "saturated count", int'(evt_count), MAXC);

    // high-frequency only
    do_reset(2'd2);
    send(0, 300);
    chk("R2", "lf sample ignored in mode 2", int'(base_valid), 0);
    send(1, 50);
    chk("R2", "hf baseline in mode 2", int'({base_valid, base_chan}), 3);
    send(0, 900);
    chk("R2", "lf stays dark in mode 2", int'({evt_valid, lf_present}), 0);
    send(1, 70);
    chk("R2", "hf event in mode 2", int'({evt_valid, evt_chan}), 3);
    chk("R6", "hf presence on", int'(hf_present), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule